// File: doc/BRIEF.md
# Bus Transaction Event Matcher

This block watches a split-phase system bus and produces one flag per event unit. A flag rises in the cycle after a bus phase meets every condition that its unit has enabled. The address phase supplies the address, the requester ID and the command type. The data phase supplies the source ID and the initiator ID. A set of configuration inputs defines the address windows and the condition mask of each unit.

Each unit checks up to four conditions. The first is that the request address lies inside one of the shared windows, chosen by a selector. The second is that the requester ID equals the unit's agent. The third is that the command is a write. The fourth is that the data source ID and the data initiator ID both equal the unit's agent. The requester ID check keeps writes from other masters, such as a processor updating the same memory range, from raising the flag. The data-phase check needs no address, so it can spot write data in flight from one bridge. Trace sequencing, sampling and storage are handled by other blocks, which consume these flags.

Top module: `bus_event_match`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bit of `evt_o` is 0.
- R2: A window hit is inclusive, low <= address <= high, over the full address width. Both bounds hit, while low-1 and high+1 miss. Window w occupies bits [w*ADDR_W +: ADDR_W] of `win_lo_i` and of `win_hi_i`.
- R3: When the requester check is enabled, an address phase whose requester ID differs from the unit's agent does not fire the unit.
- R4: When the write check is enabled, an address phase with `a_write`=0 (a read) does not fire the unit.
- R5: When the data check is enabled, the unit fires only if `d_srcid` and `d_initid` both equal the agent. A mismatch in either one blocks the unit, and no address phase is needed.
- R6: A disabled condition counts as true. A unit with only its window check enabled fires on a read from any requester that hits the window.
- R7: A unit with all four enables at 0 never fires, whatever the bus does.
- R8: Address conditions count only when `a_valid`=1, and the data condition counts only when `d_valid`=1.
- R9: `evt_o` is registered. It goes high one clock after the qualifying phase, stays low in the cycle of that phase, and stays high for one cycle when the phase lasts one cycle.
- R10: Units are independent. Unit e uses bit e of each enable vector, selector bits [e*SEL_W +: SEL_W] and agent bits [e*ID_W +: ID_W]. Two units set to different windows fire separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Address phase valid |
| a_addr | input | ADDR_W | Request address |
| a_reqid | input | ID_W | Requester ID |
| a_write | input | 1 | 1 = write command |
| d_valid | input | 1 | Data phase valid |
| d_srcid | input | ID_W | Data source ID |
| d_initid | input | ID_W | Data initiator ID |
| win_lo_i | input | NUM_WIN*ADDR_W | Window low bounds |
| win_hi_i | input | NUM_WIN*ADDR_W | Window high bounds |
| en_win_i | input | NUM_EVT | Per-unit window check enable |
| win_sel_i | input | NUM_EVT*SEL_W | Per-unit window selector |
| en_req_i | input | NUM_EVT | Per-unit requester check enable |
| en_wr_i | input | NUM_EVT | Per-unit write check enable |
| en_dat_i | input | NUM_EVT | Per-unit data check enable |
| agent_i | input | NUM_EVT*ID_W | Per-unit agent ID |
| evt_o | output | NUM_EVT | Registered event pulses |

## Verification
The assertions check five behaviours on every cycle:
- A unit with all enables at 0 stays silent.
- Each flag traces back to a phase that was valid in the previous cycle.
- An enabled requester check implies a matching requester ID.
- An enabled write check implies a write command.
- An enabled data check implies that both data IDs matched the agent.

Only the bench scenarios can show the rest. That covers the inclusive window edges and their off-by-one misses, the zero-latency window where no pulse has yet appeared, and a unit firing on a read when only its window check is enabled. It also covers two units picking different windows in the same cycle.

// File: rtl/bus_event_match.sv
module bus_event_match #(
  parameter int ADDR_W  = 40,
  parameter int ID_W    = 4,
  parameter int NUM_WIN = 2,
  parameter int NUM_EVT = 3,
  localparam int SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      a_valid,
  input  logic [ADDR_W-1:0]         a_addr,
  input  logic [ID_W-1:0]           a_reqid,
  input  logic                      a_write,
  input  logic                      d_valid,
  input  logic [ID_W-1:0]           d_srcid,
  input  logic [ID_W-1:0]           d_initid,
  input  logic [NUM_WIN*ADDR_W-1:0] win_lo_i,
  input  logic [NUM_WIN*ADDR_W-1:0] win_hi_i,
  input  logic [NUM_EVT-1:0]        en_win_i,
  input  logic [NUM_EVT*SEL_W-1:0]  win_sel_i,
  input  logic [NUM_EVT-1:0]        en_req_i,
  input  logic [NUM_EVT-1:0]        en_wr_i,
  input  logic [NUM_EVT-1:0]        en_dat_i,
  input  logic [NUM_EVT*ID_W-1:0]   agent_i,
  output logic [NUM_EVT-1:0]        evt_o
);

  localparam int HIT_W = 1 << SEL_W;

  logic [HIT_W-1:0]   win_hit;
  logic [NUM_EVT-1:0] fire;

  for (genvar w = 0; w < HIT_W; w++) begin : g_win
    if (w < NUM_WIN) begin : g_real
      assign win_hit[w] = (a_addr >= win_lo_i[w*ADDR_W +: ADDR_W]) &&
                          (a_addr <= win_hi_i[w*ADDR_W +: ADDR_W]);
    end else begin : g_pad
      assign win_hit[w] = 1'b0;
    end
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    logic [ID_W-1:0]  agent;
    logic [SEL_W-1:0] sel;
    logic             addr_used, addr_ok, dat_ok;

    assign agent     = agent_i[e*ID_W +: ID_W];
    assign sel       = win_sel_i[e*SEL_W +: SEL_W];
    assign addr_used = en_win_i[e] | en_req_i[e] | en_wr_i[e];

    assign addr_ok = !addr_used ||
                     (a_valid &&
                      (!en_win_i[e] || win_hit[sel]) &&
                      (!en_req_i[e] || (a_reqid == agent)) &&
                      (!en_wr_i[e]  || a_write));

    assign dat_ok  = !en_dat_i[e] ||
                     (d_valid && (d_srcid == agent) && (d_initid == agent));

    assign fire[e] = (addr_used | en_dat_i[e]) & addr_ok & dat_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_o <= '0;
    else        evt_o <= fire;
  end

endmodule

// File: rtl/bus_event_match_chk.sv
module bus_event_match_chk #(
  parameter int ID_W    = 4,
  parameter int NUM_EVT = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    a_valid,
  input logic [ID_W-1:0]         a_reqid,
  input logic                    a_write,
  input logic                    d_valid,
  input logic [ID_W-1:0]         d_srcid,
  input logic [ID_W-1:0]         d_initid,
  input logic [NUM_EVT-1:0]      en_win_i,
  input logic [NUM_EVT-1:0]      en_req_i,
  input logic [NUM_EVT-1:0]      en_wr_i,
  input logic [NUM_EVT-1:0]      en_dat_i,
  input logic [NUM_EVT*ID_W-1:0] agent_i,
  input logic [NUM_EVT-1:0]      evt_o
);

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_chk
    // R7
    silent_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_win_i[e] | en_req_i[e] | en_wr_i[e] | en_dat_i[e]) |=> !evt_o[e]);

    // R8
    valid_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[e] |-> $past(a_valid | d_valid));

    // R3
    reqid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o[e] && $past(en_req_i[e])) |->
        ($past(a_valid) && $past(a_reqid) == $past(agent_i[e*ID_W +: ID_W])));

    // R4
    write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o[e] && $past(en_wr_i[e])) |-> $past(a_valid & a_write));

    // R5
    data_ids_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o[e] && $past(en_dat_i[e])) |->
        ($past(d_valid) &&
         $past(d_srcid)  == $past(agent_i[e*ID_W +: ID_W]) &&
         $past(d_initid) == $past(agent_i[e*ID_W +: ID_W])));
  end

endmodule

bind bus_event_match bus_event_match_chk #(.ID_W(ID_W), .NUM_EVT(NUM_EVT)) u_chk (.*);

// File: tb/bus_event_match_tb.sv
module bus_event_match_tb;
  localparam int AW = 40, IW = 4, NW = 2, NE = 3, SW = 1;

  logic clk = 0, rst_n = 0;
  logic a_valid = 0, a_write = 0, d_valid = 0;
  logic [AW-1:0] a_addr = '0;
  logic [IW-1:0] a_reqid = '0, d_srcid = '0, d_initid = '0;
  logic [NW*AW-1:0] win_lo = '0, win_hi = '0;
  logic [NE-1:0] en_win = '0, en_req = '0, en_wr = '0, en_dat = '0;
  logic [NE*SW-1:0] win_sel = '0;
  logic [NE*IW-1:0] agent = '0;
  logic [NE-1:0] evt;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bus_event_match #(.ADDR_W(AW), .ID_W(IW), .NUM_WIN(NW), .NUM_EVT(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_addr(a_addr), .a_reqid(a_reqid),
    .a_write(a_write), .d_valid(d_valid), .d_srcid(d_srcid), .d_initid(d_initid),
    .win_lo_i(win_lo), .win_hi_i(win_hi), .en_win_i(en_win), .win_sel_i(win_sel),
    .en_req_i(en_req), .en_wr_i(en_wr), .en_dat_i(en_dat), .agent_i(agent), .evt_o(evt));

  task automatic check(input string req, input logic [NE-1:0] got, input logic [NE-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic clear_cfg();
    en_win = '0; en_req = '0; en_wr = '0; en_dat = '0; win_sel = '0; agent = '0;
  endtask

  task automatic set_unit(input int e, input logic w, input logic s, input logic r,
                          input logic wr, input logic d, input logic [IW-1:0] ag);
    en_win[e] = w; win_sel[e*SW +: SW] = s; en_req[e] = r;
    en_wr[e] = wr; en_dat[e] = d; agent[e*IW +: IW] = ag;
  endtask

  task automatic phase(input logic av, input logic [AW-1:0] ad, input logic [IW-1:0] rq,
                       input logic wr, input logic dv, input logic [IW-1:0] s,
                       input logic [IW-1:0] i, output logic [NE-1:0] got);
    @(negedge clk);
    a_valid = av; a_addr = ad; a_reqid = rq; a_write = wr;
    d_valid = dv; d_srcid = s; d_initid = i;
    @(negedge clk);
    got = evt;
    a_valid = 0; d_valid = 0;
  endtask

  task automatic t_reset();
    check("R1 in reset", evt, '0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 after reset", evt, '0);
  endtask

  task automatic t_window();
    logic [NE-1:0] g;
    clear_cfg(); set_unit(0, 1, 0, 1, 1, 0, 4'd5);
    phase(1, 40'h1000, 5, 1, 0, 0, 0, g); check("R2 low bound", g, 3'b001);
    phase(1, 40'h1FFF, 5, 1, 0, 0, 0, g); check("R2 high bound", g, 3'b001);
    phase(1, 40'h0FFF, 5, 1, 0, 0, 0, g); check("R2 below low", g, 3'b000);
    phase(1, 40'h2000, 5, 1, 0, 0, 0, g); check("R2 above high", g, 3'b000);
    phase(1, 40'h1800, 3, 1, 0, 0, 0, g); check("R3 other requester", g, 3'b000);
    phase(1, 40'h1800, 5, 0, 0, 0, 0, g); check("R4 read", g, 3'b000);
    phase(0, 40'h1800, 5, 1, 0, 0, 0, g); check("R8 no a_valid", g, 3'b000);
  endtask

  task automatic t_data();
    logic [NE-1:0] g;
    clear_cfg(); set_unit(2, 0, 0, 0, 0, 1, 4'd5);
    phase(0, 0, 0, 0, 1, 5, 5, g); check("R5 both ids match", g, 3'b100);
    phase(0, 0, 0, 0, 1, 5, 4, g); check("R5 initiator differs", g, 3'b000);
    phase(0, 0, 0, 0, 1, 4, 5, g); check("R5 source differs", g, 3'b000);
    phase(0, 0, 0, 0, 0, 5, 5, g); check("R8 no d_valid", g, 3'b000);
  endtask

  task automatic t_disabled_true();
    logic [NE-1:0] g;
    clear_cfg(); set_unit(1, 1, 1, 0, 0, 0, 4'd5);
    phase(1, 40'h8_0000_0010, 7, 0, 0, 0, 0, g); check("R6 read any requester", g, 3'b010);
  endtask

  task automatic t_all_off();
    logic [NE-1:0] g;
    clear_cfg();
    phase(1, 40'h1000, 0, 1, 1, 0, 0, g); check("R7 all disabled", g, 3'b000);
  endtask

  task automatic t_latency();
    clear_cfg(); set_unit(0, 1, 0, 0, 0, 0, 4'd0);
    @(negedge clk);
    a_valid = 1; a_addr = 40'h1234; a_write = 0;
    #1 check("R9 same cycle", evt, 3'b000);
    @(negedge clk); check("R9 next cycle", evt, 3'b001);
    a_valid = 0;
    @(negedge clk); check("R9 single pulse", evt, 3'b000);
  endtask

  task automatic t_independent();
    logic [NE-1:0] g;
    clear_cfg(); set_unit(0, 1, 0, 0, 0, 0, 0); set_unit(1, 1, 1, 0, 0, 0, 0);
    phase(1, 40'h1500, 0, 1, 0, 0, 0, g); check("R10 window0 only", g, 3'b001);
    phase(1, 40'h8_0000_0100, 0, 1, 0, 0, 0, g); check("R10 window1 only", g, 3'b010);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    win_lo[0 +: AW] = 40'h1000;       win_hi[0 +: AW] = 40'h1FFF;
    win_lo[AW +: AW] = 40'h8_0000_0000; win_hi[AW +: AW] = 40'h8_0000_FFFF;
    @(negedge clk);
    t_reset();
    t_window();
    t_data();
    t_disabled_true();
    t_all_off();
    t_latency();
    t_independent();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule